// File: doc/BRIEF.md
# Ethernet PHY Interrupt Flag and Mask Unit

This block watches four live status lines of an Ethernet PHY (link up, wake event, energy detect and auto-negotiation complete). Each line can raise its own interrupt flag. A software-visible flag register collects these flags, and a mask register chooses which flags may drive a single interrupt line toward the system interrupt controller. The unit is reached through a plain register read/write port of the kind a management-interface front end would drive.

A flag tracks its source rather than latching forever. A flag is set when its source rises. It is cleared either when the source drops again or when software reads the flag register, whichever happens first. A read returns the flags as they stood before that read cleared them. If a new rising edge arrives in the same cycle as the read, the flag stays set so that the event is not lost. Reads of addresses the unit does not implement return all ones.

Top module: `phy_irq_unit`

## Requirements
- R1: After reset all flags and all mask bits are zero, `irq_o` is low, and reads of address 29 and address 30 return 16'h0000.
- R2: A rising edge on a source sets its flag bit in register 29 within three clock edges of the input change. The bit positions are: bit 9 link (`src_i[3]`), bit 8 wake (`src_i[2]`), bit 7 energy (`src_i[1]`), bit 6 auto-negotiation (`src_i[0]`).
- R3: A set flag clears when its source falls, even if register 29 is never read.
- R4: A read of register 29 returns the flag values from before the read and clears every flag. A source that stays high does not set its flag again.
- R5: A rising edge that reaches the flag logic in the same cycle as a register 29 read leaves that flag set after the read.
- R6: Register 30 bits 9..6 are writable mask bits that enable flag bits 9..6. All other bits of registers 29 and 30 read as zero.
- R7: Writes to register 29 have no effect on the flags.
- R8: `irq_o` is high exactly when some flag and its mask bit are both set. It is registered, so it follows a flag or mask change one clock later.
- R9: A read of any address other than 29 or 30 returns 16'hFFFF.
- R10: Clearing a mask bit drops `irq_o` without altering the flag it masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 4 | Asynchronous status levels: [3] link, [2] wake, [1] energy, [0] auto-negotiation |
| reg_addr_i | input | 5 | Register address |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current address, valid while the read strobe is high |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
The assertions assume the following about the inputs:
- The read and write strobes are each a single-cycle pulse.
- A read and a write never share a cycle.
- The properties relate the flags to the synchronised source levels, not to the raw pins. Because of this, any timing of `src_i` is legal.

The stimulus respects these assumptions:
- It drives every input on the falling clock edge.
- It issues only one bus access at a time.
- It waits five cycles after each source change before it checks the settled flags.
- The one deliberately aligned case places a flag read in the exact cycle where the synchronised rising edge appears.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    // Source index order; flag bit = FIELD_LSB + index
    typedef enum logic [1:0] {
        SRC_ANEG   = 2'd0,
        SRC_ENERGY = 2'd1,
        SRC_WAKE   = 2'd2,
        SRC_LINK   = 2'd3
    } src_idx_e;

    localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/phy_irq_edge_flags.sv
module phy_irq_edge_flags #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic             rd_clr_i,
    output logic [WIDTH-1:0] flags_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise      = level_i & ~st_q.prev;
        fall      = ~level_i & st_q.prev;
        for (int b = 0; b < int'(WIDTH); b++) begin
            if (rise[b])                 st_d.flags[b] = 1'b1;   // new event wins over clear
            else if (fall[b] || rd_clr_i) st_d.flags[b] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/phy_irq_regfile.sv
module phy_irq_regfile #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned FLAG_ADDR = 29,
    parameter int unsigned MASK_ADDR = 30,
    parameter int unsigned FIELD_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WIDTH-1:0]  flags_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic              rd_clr_o
);

    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic hit_flag, hit_mask;
    logic unused_wbits;

    assign hit_flag     = (addr_i == FLAG_A);
    assign hit_mask     = (addr_i == MASK_A);
    assign unused_wbits = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (wr_i && hit_mask) begin
            st_d.mask = wdata_i[FIELD_LSB +: WIDTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (hit_flag)      rdata_o = DATA_W'(flags_i) << FIELD_LSB;
        else if (hit_mask) rdata_o = DATA_W'(st_q.mask) << FIELD_LSB;
        else               rdata_o = '1;
    end

    assign mask_o   = st_q.mask;
    assign rd_clr_o = rd_i && hit_flag;

endmodule

// File: rtl/phy_irq_unit.sv
module phy_irq_unit #(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned N_SRC       = phy_irq_pkg::NUM_SRC,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FLAG_ADDR   = 29,
    parameter int unsigned MASK_ADDR   = 30,
    parameter int unsigned FIELD_LSB   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [N_SRC-1:0] sync_vec;
    logic [N_SRC-1:0] flag_vec;
    logic [N_SRC-1:0] mask_vec;
    logic             rd_clr;

    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t st_d, st_q;

    phy_irq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (sync_vec)
    );

    phy_irq_edge_flags #(.WIDTH(N_SRC)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (sync_vec),
        .rd_clr_i (rd_clr),
        .flags_o  (flag_vec)
    );

    phy_irq_regfile #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WIDTH     (N_SRC),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_ADDR (MASK_ADDR),
        .FIELD_LSB (FIELD_LSB)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr_i),
        .rd_i     (reg_rd_i),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .flags_i  (flag_vec),
        .rdata_o  (reg_rdata_o),
        .mask_o   (mask_vec),
        .rd_clr_o (rd_clr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(flag_vec & mask_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned N         = 4,
    parameter int unsigned FLAG_ADDR = 29,
    parameter int unsigned MASK_ADDR = 30,
    parameter int unsigned FIELD_LSB = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_rd_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [N-1:0]      lvl,
    input logic [N-1:0]      flags,
    input logic [N-1:0]      mask
);

    localparam logic [DATA_W-1:0] FIELD_M = DATA_W'(((1 << N) - 1) << FIELD_LSB);

    logic flag_rd, mask_rd, other_rd;
    assign flag_rd  = reg_rd_i && (reg_addr_i == ADDR_W'(FLAG_ADDR));
    assign mask_rd  = reg_rd_i && (reg_addr_i == ADDR_W'(MASK_ADDR));
    assign other_rd = reg_rd_i && !flag_rd && !mask_rd;

    AST_UNSUP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |-> (reg_rdata_o == '1));                                     // R9
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd || mask_rd) |-> ((reg_rdata_o & ~FIELD_M) == '0));            // R6
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lvl & ~$past(lvl))) |=> ((flags & $past(lvl & ~$past(lvl))) == $past(lvl & ~$past(lvl)))); // R2
    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~lvl & $past(lvl))) |=> ((flags & $past(~lvl & $past(lvl))) == '0)); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> ((flags & ~$past(lvl & ~$past(lvl))) == '0));               // R4
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & mask)) |=> irq_o);                                           // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & mask)) |=> !irq_o);                                         // R10

endmodule

bind phy_irq_unit phy_irq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .N         (N_SRC),
    .FLAG_ADDR (FLAG_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .FIELD_LSB (FIELD_LSB)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .lvl         (sync_vec),
    .flags       (flag_vec),
    .mask        (mask_vec)
);

// File: tb/phy_irq_unit_tb_top.sv
module phy_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src = '0;
    logic [4:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    phy_irq_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_rd_i    (rd),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [15:0] mask_w;
        logic [3:0]  src;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h03C0, 4'b0001, 1'b1},
        '{16'h0200, 4'b0001, 1'b0},
        '{16'h0200, 4'b1000, 1'b1},
        '{16'hFC3F, 4'b1111, 1'b0},
        '{16'h0100, 4'b0110, 1'b1},
        '{16'h0080, 4'b1001, 1'b0},
        '{16'h0040, 4'b1111, 1'b1},
        '{16'h0000, 4'b1111, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        wait_cyc(3);
        // R1 reset state
        check("R1 irq", {15'd0, irq}, 16'h0);
        rst_n = 1'b1;
        wait_cyc(2);
        bus_read(5'd29, d); check("R1 flags", d, 16'h0000);
        bus_read(5'd30, d); check("R1 mask", d, 16'h0000);
        check("R1 irq after release", {15'd0, irq}, 16'h0);

        // R9 unsupported addresses
        bus_read(5'd0, d);  check("R9 addr0", d, 16'hFFFF);
        bus_read(5'd28, d); check("R9 addr28", d, 16'hFFFF);
        bus_read(5'd31, d); check("R9 addr31", d, 16'hFFFF);

        // Vector table: R2 R4 R6 R8
        for (int i = 0; i < NV; i++) begin
            src = '0;
            wait_cyc(5);
            bus_read(5'd29, d);
            bus_write(5'd30, VECS[i].mask_w);
            bus_read(5'd30, d); check("R6 mask readback", d, VECS[i].mask_w & 16'h03C0);
            @(negedge clk); src = VECS[i].src;
            wait_cyc(5);
            check("R8 irq vector", {15'd0, irq}, {15'd0, VECS[i].exp_irq});
            bus_read(5'd29, d); check("R2 R4 flags vector", d, {6'd0, VECS[i].src, 6'd0});
            wait_cyc(2);
            check("R4 irq after read", {15'd0, irq}, 16'h0);
            bus_read(5'd29, d); check("R4 no re-set while high", d, 16'h0000);
        end

        // R3 fall clears without a read
        src = '0; wait_cyc(5);
        bus_write(5'd30, 16'h03C0);
        @(negedge clk); src = 4'b0010;
        wait_cyc(5);
        check("R3 irq set", {15'd0, irq}, 16'h1);
        @(negedge clk); src = 4'b0000;
        wait_cyc(5);
        check("R3 irq after fall", {15'd0, irq}, 16'h0);
        bus_read(5'd29, d); check("R3 flag after fall", d, 16'h0000);

        // R7 write to flag register ignored
        @(negedge clk); src = 4'b1000;
        wait_cyc(5);
        bus_write(5'd29, 16'h0000);
        wait_cyc(1);
        bus_read(5'd29, d); check("R7 write zero ignored", d, 16'h0200);
        bus_write(5'd29, 16'hFFFF);
        wait_cyc(1);
        bus_read(5'd29, d); check("R7 write ones ignored", d, 16'h0000);
        src = '0; wait_cyc(5);

        // R5 rise coincident with read
        @(negedge clk); src = 4'b0001;
        wait_cyc(5);
        @(negedge clk); src = 4'b1001;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 5'd29; rd = 1'b1;
        #1 d = rdata;
        check("R5 pre-clear value", d, 16'h0040);
        @(negedge clk); rd = 1'b0;
        bus_read(5'd29, d); check("R5 new event kept", d, 16'h0200);
        src = '0; wait_cyc(5);

        // R10 / R8 latency: mask drop leaves flag
        @(negedge clk); src = 4'b0100;
        wait_cyc(5);
        check("R10 irq before", {15'd0, irq}, 16'h1);
        bus_write(5'd30, 16'h0000);
        check("R8 irq one cycle latency", {15'd0, irq}, 16'h1);
        wait_cyc(1);
        check("R10 irq after mask clear", {15'd0, irq}, 16'h0);
        bus_read(5'd29, d); check("R10 flag intact", d, 16'h0100);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule